// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block turns the serial output of a UART into the short infrared pulses of an IrDA SIR link. It samples the transmit data line in the crystal-clock domain through a small synchronizer. It also takes a one-cycle enable that a rate generator outside the block raises sixteen times per bit period. Each bit period in which the data line is low produces one high pulse on the optical drive output. A high data line produces no light. A falling edge of the data line starts the bit timing, so the encoder follows the start bit of every character.

Two pulse widths are available. In the normal mode a pulse lasts three ticks of the 16x enable, which is 3/16 of a bit period and scales with the baud rate. With the mode input held high, every pulse lasts a fixed six crystal-clock cycles whatever the rate selection. With a 3.6864 MHz crystal that is about 1.63 µs. The fixed mode is only meaningful when the crystal clock drives the block, not when a 16x clock is supplied from outside. The mode input is meant to be tied low unless the fixed width is wanted.

Top module: `irda_pulse_enc`

## Requirements
- R1: While `rstN` is low (synchronous, active low), `irTxd` is low on every clock, whatever `txd` does.
- R2: With `txd` held high and no falling edge, `irTxd` stays low.
- R3: A falling edge on `txd` raises `irTxd` on the third rising clock edge after the change: two synchronizer stages plus the output register.
- R4: In normal mode (`fixedMode` = 0) a pulse stays high until the clock edge at which the third `tick16` after its start is sampled, then drops on that edge, for any tick spacing.
- R5: While `txd` stays low, a new pulse starts on the clock edge at which the sixteenth `tick16` after the previous pulse start is sampled.
- R6: In fixed mode (`fixedMode` = 1) every pulse is high for exactly 6 clock cycles, independent of the `tick16` spacing.
- R7: A pulse already started runs to its full width even if `txd` rises during it, and once `txd` is high at a bit boundary no further pulse is produced.
- R8: A falling edge of `txd` in the middle of a bit period restarts the bit timing: the pulse follows R3 and the next pulse is sixteen ticks after it.
- R9: Asserting `rstN` during a pulse forces `irTxd` low on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| txd | input | 1 | Serial data from the UART, idle high |
| fixedMode | input | 1 | 1 selects the fixed six-cycle pulse, 0 the 3/16 pulse |
| irTxd | output | 1 | Drive to the infrared emitter, high means light |

## Verification
The bench measures pulse width in ticks and bit spacing in ticks at two tick spacings. A design that counted clocks instead of ticks, or that was off by one in the phase counter, would show a width of 2 or 4 ticks or a spacing of 15 or 17. It raises the data line during a pulse and checks that the pulse is not cut short and that no stray pulse follows. It also drops the data line again in mid-bit, where a design that kept its old phase would fire at the stale boundary instead of sixteen ticks after the new edge. Fixed mode is checked at two tick rates for a width of exactly six cycles. Reset is applied mid-pulse, where a design with a lazy or asynchronous-only clear would leave light on.

// File: rtl/irda_pulse_pkg.sv
package irda_pulse_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic startPulse;
    logic endPulse;
    logic clrPhase;
    logic incPhase;
  } pulseStrb_t;

  // Status from datapath to control
  typedef struct packed {
    logic phaseWrap;
    logic normDone;
    logic fixedDone;
    logic pulseOn;
  } pulseStat_t;

endpackage

// File: rtl/irda_pulse_dp.sv
module irda_pulse_dp
  import irda_pulse_pkg::*;
#(
  parameter int PHASES       = 16,
  parameter int NORM_TICKS   = 3,
  parameter int FIXED_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  pulseStrb_t strb,
  output pulseStat_t stat,
  output logic       irTxd
);

  localparam int PW = $clog2(PHASES);
  localparam int WW = $clog2(FIXED_CYCLES + 1);

  logic [PW-1:0] phaseQ;
  logic [WW-1:0] widthQ;
  logic          pulseQ;

  // Tick position inside the current bit period
  always_ff @(posedge clk) begin
    if (!rstN)               phaseQ <= '0;
    else if (strb.clrPhase)  phaseQ <= '0;
    else if (strb.incPhase)  phaseQ <= phaseQ + 1'b1;
  end

  // Clock cycles since pulse start, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                                 widthQ <= '0;
    else if (strb.startPulse)                  widthQ <= '0;
    else if (pulseQ && widthQ < WW'(FIXED_CYCLES)) widthQ <= widthQ + 1'b1;
  end

  // Output register
  always_ff @(posedge clk) begin
    if (!rstN)               pulseQ <= 1'b0;
    else if (strb.startPulse) pulseQ <= 1'b1;
    else if (strb.endPulse)   pulseQ <= 1'b0;
  end

  always_comb begin
    stat.phaseWrap = (phaseQ == PW'(PHASES - 1));
    stat.normDone  = (phaseQ >= PW'(NORM_TICKS - 1));
    stat.fixedDone = (widthQ >= WW'(FIXED_CYCLES - 1));
    stat.pulseOn   = pulseQ;
  end

  assign irTxd = pulseQ;

endmodule

// File: rtl/irda_pulse_ctrl.sv
module irda_pulse_ctrl
  import irda_pulse_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       txd,
  input  logic       fixedMode,
  input  pulseStat_t stat,
  output pulseStrb_t strb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   activeQ;
  logic                   txdS, fall, boundary, startNow, endNow;

  // Synchronizer and edge history, reset to the idle (high) level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], txd};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign txdS     = syncQ[SYNC_STAGES-1];
  assign fall     = prevQ & ~txdS;
  assign boundary = activeQ & tick16 & stat.phaseWrap;
  assign startNow = fall | (boundary & ~txdS);
  assign endNow   = stat.pulseOn &
                    (fixedMode ? stat.fixedDone : (tick16 & stat.normDone));

  // Bit timing runs from a falling edge until a boundary finds the line high
  always_ff @(posedge clk) begin
    if (!rstN)                activeQ <= 1'b0;
    else if (fall)            activeQ <= 1'b1;
    else if (boundary && txdS) activeQ <= 1'b0;
  end

  always_comb begin
    strb.startPulse = startNow;
    strb.endPulse   = endNow & ~startNow;
    strb.clrPhase   = startNow | boundary;
    strb.incPhase   = activeQ & tick16 & ~(startNow | boundary);
  end

  a_r3_fall_starts: assert property (@(posedge clk) disable iff (!rstN)
    fall |=> stat.pulseOn);

  a_r5_boundary_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !txdS) |=> stat.pulseOn);

  a_r4_normal_end: assert property (@(posedge clk) disable iff (!rstN)
    (stat.pulseOn && !fixedMode && tick16 && stat.normDone && !startNow)
      |=> !stat.pulseOn);

  a_r6_fixed_end: assert property (@(posedge clk) disable iff (!rstN)
    (stat.pulseOn && fixedMode && stat.fixedDone && !startNow)
      |=> !stat.pulseOn);

endmodule

// File: rtl/irda_pulse_enc.sv
module irda_pulse_enc
  import irda_pulse_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PHASES       = 16,
  parameter int NORM_TICKS   = 3,
  parameter int FIXED_CYCLES = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick16,
  input  logic txd,
  input  logic fixedMode,
  output logic irTxd
);

  pulseStrb_t strb;
  pulseStat_t stat;

  irda_pulse_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .txd(txd),
    .fixedMode(fixedMode), .stat(stat), .strb(strb)
  );

  irda_pulse_dp #(
    .PHASES(PHASES), .NORM_TICKS(NORM_TICKS), .FIXED_CYCLES(FIXED_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat), .irTxd(irTxd)
  );

endmodule

// File: tb/irda_pulse_enc_tb_top.sv
`timescale 1ns/1ps
module irda_pulse_enc_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic txd = 1'b1;
  logic fixedMode = 1'b0;
  logic irTxd;

  int tickPeriod = 4;
  int tdiv = 0;
  int checks = 0;
  int errors = 0;

  irda_pulse_enc dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .txd(txd),
    .fixedMode(fixedMode), .irTxd(irTxd)
  );

  always #2 clk = ~clk;

  // 16x enable generator
  always @(posedge clk) begin
    if (tdiv >= tickPeriod - 1) begin
      tdiv   <= 0;
      tick16 <= 1'b1;
    end else begin
      tdiv   <= tdiv + 1;
      tick16 <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Holds irTxd low for n cycles, one check in total
  task automatic expectQuiet(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irTxd !== 1'b0) highs++;
    end
    check(highs == 0, req, "high cycles while quiet", highs, 0);
  endtask

  // Drops txd at a negedge and checks the R3 latency; ends on the rise negedge
  task automatic fallAndLatency(input string req);
    @(negedge clk);
    txd = 1'b0;
    @(negedge clk);
    check(irTxd === 1'b0, req, "irTxd one edge after fall", int'(irTxd), 0);
    @(negedge clk);
    check(irTxd === 1'b0, req, "irTxd two edges after fall", int'(irTxd), 0);
    @(negedge clk);
    check(irTxd === 1'b1, req, "irTxd three edges after fall", int'(irTxd), 1);
  endtask

  // Called on the negedge where irTxd is high for the first time
  task automatic measureBit(input int limit, output int width, output int pTicks,
                            output int lastTick, output int perTicks);
    bit high = 1'b1;
    width = 0; pTicks = 0; lastTick = 0; perTicks = 0;
    for (int n = 0; n < limit; n++) begin
      if (!high && irTxd === 1'b1) return;
      if (high && irTxd !== 1'b1) high = 1'b0;
      if (high) begin
        width++;
        pTicks  += int'(tick16);
        lastTick = int'(tick16);
      end
      perTicks += int'(tick16);
      @(negedge clk);
    end
    perTicks = -1;
  endtask

  task automatic testReset();
    int highs = 0;
    rstN = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      txd = (i % 3 == 0) ? 1'b0 : 1'b1;
      if (irTxd !== 1'b0) highs++;
    end
    check(highs == 0, "R1", "irTxd high during reset", highs, 0);
    txd = 1'b1;
    @(negedge clk);
    check(irTxd === 1'b0, "R1", "irTxd at reset release", int'(irTxd), 0);
    rstN = 1'b1;
  endtask

  task automatic testIdle();
    txd = 1'b1;
    expectQuiet(120, "R2");
  endtask

  task automatic testNormal(input int period);
    int w, pt, lt, per;
    tickPeriod = period;
    fixedMode  = 1'b0;
    repeat (20) @(negedge clk);
    fallAndLatency("R3");
    for (int b = 0; b < 2; b++) begin
      measureBit(400, w, pt, lt, per);
      check(pt == 3 && lt == 1, "R4", "ticks inside normal pulse", pt, 3);
      check(per == 16, "R5", "ticks between pulse starts", per, 16);
    end
    txd = 1'b1;
    measureBit(40 * period, w, pt, lt, per);
    check(pt == 3 && lt == 1, "R7", "ticks in pulse cut by txd rise", pt, 3);
    check(per == -1, "R7", "extra pulse after txd high", per, -1);
  endtask

  task automatic testFixed(input int period);
    int w, pt, lt, per;
    tickPeriod = period;
    @(negedge clk);
    fixedMode = 1'b1;
    repeat (20) @(negedge clk);
    fallAndLatency("R3");
    measureBit(400, w, pt, lt, per);
    check(w == 6, "R6", "fixed pulse width", w, 6);
    check(per == 16, "R5", "fixed mode ticks between starts", per, 16);
    txd = 1'b1;
    measureBit(40 * period, w, pt, lt, per);
    check(w == 6, "R6", "fixed width last pulse", w, 6);
    check(per == -1, "R7", "extra fixed pulse after txd high", per, -1);
    @(negedge clk);
    fixedMode = 1'b0;
  endtask

  task automatic testResync();
    int w, pt, lt, per;
    tickPeriod = 4;
    fixedMode  = 1'b0;
    repeat (10) @(negedge clk);
    fallAndLatency("R8");
    repeat (20) @(negedge clk);
    txd = 1'b1;
    expectQuiet(4, "R8");
    fallAndLatency("R8");
    measureBit(400, w, pt, lt, per);
    check(per == 16, "R8", "ticks to next pulse after mid-bit edge", per, 16);
    txd = 1'b1;
    measureBit(200, w, pt, lt, per);
    check(per == -1, "R8", "pulse after resync ends", per, -1);
  endtask

  task automatic testResetMidPulse();
    tickPeriod = 8;
    fixedMode  = 1'b0;
    repeat (10) @(negedge clk);
    fallAndLatency("R3");
    rstN = 1'b0;
    @(negedge clk);
    check(irTxd === 1'b0, "R9", "irTxd after reset in pulse", int'(irTxd), 0);
    txd = 1'b1;
    expectQuiet(3, "R9");
    rstN = 1'b1;
    expectQuiet(200, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testIdle();
    testNormal(4);
    testNormal(8);
    testFixed(4);
    testFixed(8);
    testResync();
    testResetMidPulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule